// File: doc/BRIEF.md
# Eight-Channel Interrupt Status Aggregator

This block gathers the selected flag outputs of eight counting channels into one interrupt structure that a host can read and control. Each channel has an enable bit and a latched pending bit. A pending bit is set when that channel's flag rises while its enable bit is set. The block drives one shared interrupt request line, which is active only while the global interrupt function is switched on and at least one pending bit is set.

The host uses a synchronous, byte-wide register port with an address, write data, a write strobe and combinational read data. Three addresses are decoded. The status register is read-only. The enable register can be read and written. The channel-operation register accepts command bytes. One command clears every pending bit and switches the interrupt function on. Another command resets the external counters, through a one-cycle strobe, and switches the interrupt function off. A typical handler reads status, services every set bit, and then issues the clear command. A status value of zero tells the handler that the interrupt came from another source on the shared line.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, status reads 0x00, enable reads 0x00, the interrupt function is off and `irqO` is low.
- R2: A write to address 0x12 stores the byte as the enable register, with bit i belonging to channel i. A read of 0x12 returns the stored byte.
- R3: Status bit i is set on the clock edge at which `flagIn[i]` is high after being low on the previous edge, provided enable bit i is set on that edge. A flag that stays high sets nothing further, and a flag on a disabled channel sets nothing.
- R4: A read of address 0x10 returns the pending bits, with bit i belonging to channel i. A value of 0x00 means nothing is pending. A read of 0x11 or of any undecoded address returns 0x00.
- R5: Writing 0x04 to address 0x11 clears all pending bits and switches the interrupt function on.
- R6: Writing 0x01 to address 0x11 switches the interrupt function off and leaves the pending bits unchanged. `counterRstO` is high during that write cycle and low in all other cycles.
- R7: `irqO` is high exactly when the interrupt function is on and at least one pending bit is set.
- R8: A rising flag on an enabled channel that arrives on the same edge as the clear command leaves its pending bit set.
- R9: Clearing an enable bit does not clear a pending bit that is already set for that channel.
- R10: Writes to address 0x10 and operation bytes other than 0x01 and 0x04 change neither the status, the enable register nor the interrupt function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 5 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| flagIn | input | 8 | Selected flag output of each channel, active high |
| counterRstO | output | 1 | One-cycle strobe that resets the counters |
| irqO | output | 1 | Shared interrupt request |

## Verification
The main sweep tries all 256 enable masks. Each mask is paired with a flag pattern derived arithmetically from it. Every pending bit must equal the AND of flag and enable, and the request line must follow whether that AND is nonzero. This exposes dropped, crossed or unmasked channels. Targeted sequences cover the remaining cases:
- a flag held high across a clear command, which separates edge latching from level latching;
- a flag rising on the same edge as the clear, which checks that the new event is kept;
- an enable bit removed while its channel is pending, which checks that the bit is held;
- the reset command, which must gate the request line while status stays intact, and unknown commands, which must be ignored.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_ENABLE = 2'd2
  } rdSel_e;

  // strobes from the decoder into the datapath
  typedef struct packed {
    logic   enWr;      // load enable register
    logic   clrPend;   // clear all pending bits
    logic   funcOn;    // switch interrupt function on
    logic   funcOff;   // switch interrupt function off
    rdSel_e rdSel;     // read mux select
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
`timescale 1ns/1ps
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 5'h10,
  parameter logic [ADDR_W-1:0] OPCMD_OFS  = 5'h11,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 5'h12,
  parameter logic [DATA_W-1:0] OP_RESET   = 8'h01,
  parameter logic [DATA_W-1:0] OP_ARM     = 8'h04
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrobes_t      strobes,
  output logic              counterRst
);

  logic opWrite;

  assign opWrite = regWrEn && (regAddr == OPCMD_OFS);

  always_comb begin
    strobes         = '0;
    strobes.rdSel   = RD_NONE;
    strobes.enWr    = regWrEn && (regAddr == ENABLE_OFS);
    strobes.clrPend = opWrite && (regWrData == OP_ARM);
    strobes.funcOn  = opWrite && (regWrData == OP_ARM);
    strobes.funcOff = opWrite && (regWrData == OP_RESET);
    if (regAddr == STATUS_OFS) begin
      strobes.rdSel = RD_STATUS;
    end else if (regAddr == ENABLE_OFS) begin
      strobes.rdSel = RD_ENABLE;
    end
  end

  assign counterRst = opWrite && (regWrData == OP_RESET);

endmodule

// File: rtl/irq_agg_data.sv
`timescale 1ns/1ps
module irq_agg_data
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] flagIn,
  output logic [NUM_CH-1:0] statusVec,
  output logic [NUM_CH-1:0] enableVec,
  output logic              funcEn,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - NUM_CH;

  logic [NUM_CH-1:0] flagPrevQ;
  logic [NUM_CH-1:0] riseEvt;
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] enableQ;
  logic              funcEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagPrevQ <= '0;
      enableQ   <= '0;
      funcEnQ   <= 1'b0;
    end else begin
      flagPrevQ <= flagIn;
      if (strobes.enWr) begin
        enableQ <= wrData[NUM_CH-1:0];
      end
      if (strobes.funcOn) begin
        funcEnQ <= 1'b1;
      end else if (strobes.funcOff) begin
        funcEnQ <= 1'b0;
      end
    end
  end

  assign riseEvt = flagIn & ~flagPrevQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ[ch] <= 1'b0;
      end else begin
        statusQ[ch] <= (statusQ[ch] & ~strobes.clrPend) | (riseEvt[ch] & enableQ[ch]);
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      RD_STATUS: rdData = {{PAD_W{1'b0}}, statusQ};
      RD_ENABLE: rdData = {{PAD_W{1'b0}}, enableQ};
      default:   rdData = '0;
    endcase
  end

  assign statusVec = statusQ;
  assign enableVec = enableQ;
  assign funcEn    = funcEnQ;

endmodule

// File: rtl/irq_status_agg.sv
`timescale 1ns/1ps
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] flagIn,
  output logic              counterRstO,
  output logic              irqO
);

  ctrlStrobes_t      strobes;
  logic [NUM_CH-1:0] statusVec;
  logic [NUM_CH-1:0] enableVec;
  logic              funcEn;

  irq_agg_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobes   (strobes),
    .counterRst(counterRstO)
  );

  irq_agg_data #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (regWrData),
    .flagIn   (flagIn),
    .statusVec(statusVec),
    .enableVec(enableVec),
    .funcEn   (funcEn),
    .rdData   (regRdData)
  );

  assign irqO = funcEn & (|statusVec);

endmodule

// File: rtl/irq_status_agg_chk.sv
`timescale 1ns/1ps
module irq_status_agg_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [NUM_CH-1:0] statusVec,
  input logic [NUM_CH-1:0] enableVec,
  input logic              funcEn,
  input logic              irqO
);

  logic armCmd;
  logic rstCmd;

  assign armCmd = regWrEn && (regAddr == 5'h11) && (regWrData == 8'h04);
  assign rstCmd = regWrEn && (regAddr == 5'h11) && (regWrData == 8'h01);

  // R5: the arm command turns the interrupt function on
  a_r5_arm_on: assert property (@(posedge clk) disable iff (!rstN)
    armCmd |=> funcEn);

  // R6: the reset command turns the interrupt function off
  a_r6_rst_off: assert property (@(posedge clk) disable iff (!rstN)
    rstCmd |=> !funcEn);

  // R3: a new pending bit appears only on a channel that was enabled
  a_r3_masked_latch: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVec & ~$past(statusVec) & ~$past(enableVec)) == '0));

  // R9: without a clear command, pending bits are never dropped
  a_r9_hold_pending: assert property (@(posedge clk) disable iff (!rstN)
    !armCmd |=> ((statusVec & $past(statusVec)) == $past(statusVec)));

  // R7: a request needs both a pending bit and the function switched on
  a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    irqO |-> ((statusVec != '0) && funcEn));

endmodule

bind irq_status_agg irq_status_agg_chk #(
  .NUM_CH(NUM_CH),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .statusVec(statusVec),
  .enableVec(enableVec),
  .funcEn   (funcEn),
  .irqO     (irqO)
);

// File: tb/irq_status_agg_test.sv
`timescale 1ns/1ps
module irq_status_agg_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_STAT = 5'h10;
  localparam logic [4:0] A_OP   = 5'h11;
  localparam logic [4:0] A_EN   = 5'h12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] flagIn = '0;
  logic       counterRstO;
  logic       irqO;

  int checks = 0;
  int failures = 0;

  irq_status_agg uut (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .flagIn     (flagIn),
    .counterRstO(counterRstO),
    .irqO       (irqO)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic setFlags(input logic [7:0] f);
    @(negedge clk);
    flagIn = f;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(A_STAT, rd); check("R1 status", rd, 8'h00);
    rdReg(A_EN, rd);   check("R1 enable", rd, 8'h00);
    check("R1 irq", irqO, 0);
    check("R1 counterRst", counterRstO, 0);

    // R7: pending with function still off gives no request
    wrReg(A_EN, 8'h01);
    setFlags(8'h01);
    rdReg(A_STAT, rd); check("R3 latch with func off", rd, 8'h01);
    check("R7 irq low while func off", irqO, 0);
    setFlags(8'h00);

    // R2/R3/R4/R5/R7 exhaustive sweep over the enable masks
    for (int e = 0; e < 256; e++) begin
      logic [7:0] f;
      logic [7:0] expSt;
      f = 8'((e * 37 + 11) ^ (e >> 3));
      expSt = f & 8'(e);
      wrReg(A_EN, 8'(e));
      rdReg(A_EN, rd); check("R2 enable readback", rd, e);
      wrReg(A_OP, 8'h04);
      rdReg(A_STAT, rd); check("R5 cleared", rd, 8'h00);
      setFlags(f);
      rdReg(A_STAT, rd); check("R3 masked latch", rd, expSt);
      check("R7 irq follows status", irqO, int'(expSt != 0));
      setFlags(8'h00);
    end

    // R3: a flag held high across a clear does not relatch
    wrReg(A_EN, 8'hFF);
    setFlags(8'h3C);
    wrReg(A_OP, 8'h04);
    @(negedge clk);
    rdReg(A_STAT, rd); check("R3 held level no relatch", rd, 8'h00);
    check("R4 zero status no irq", irqO, 0);
    setFlags(8'h00);

    // R8: event on the same edge as the clear is kept
    setFlags(8'h01);
    setFlags(8'h00);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_OP; regWrData = 8'h04; flagIn = 8'h80;
    @(negedge clk);
    regWrEn = 1'b0;
    rdReg(A_STAT, rd); check("R8 concurrent event kept", rd, 8'h80);
    check("R8 irq", irqO, 1);
    setFlags(8'h00);

    // R9: removing enable keeps pending, blocks new latching
    wrReg(A_OP, 8'h04);
    setFlags(8'h0F);
    wrReg(A_EN, 8'h00);
    setFlags(8'h00);
    setFlags(8'hF0);
    rdReg(A_STAT, rd); check("R9 pending kept after disable", rd, 8'h0F);
    setFlags(8'h00);

    // R10: writes to status and unknown op codes do nothing
    wrReg(A_STAT, 8'h00);
    rdReg(A_STAT, rd); check("R10 status write ignored", rd, 8'h0F);
    wrReg(A_OP, 8'h02);
    rdReg(A_STAT, rd); check("R10 unknown op status", rd, 8'h0F);
    rdReg(A_EN, rd);   check("R10 unknown op enable", rd, 8'h00);
    check("R10 unknown op keeps func", irqO, 1);
    rdReg(A_OP, rd);   check("R4 op addr reads zero", rd, 8'h00);
    rdReg(5'h03, rd);  check("R4 undecoded reads zero", rd, 8'h00);

    // R6: reset command strobe, function off, status kept
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_OP; regWrData = 8'h01;
    #1 check("R6 counterRst during write", counterRstO, 1);
    @(negedge clk);
    regWrEn = 1'b0;
    #1 check("R6 counterRst after write", counterRstO, 0);
    rdReg(A_STAT, rd); check("R6 status kept", rd, 8'h0F);
    check("R6 irq gated", irqO, 0);
    wrReg(A_OP, 8'h04);
    rdReg(A_STAT, rd); check("R5 clear after rearm", rd, 8'h00);
    check("R5 irq low after clear", irqO, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule